// File: doc/BRIEF.md
# Video Control Port Command Decoder

This block is the front end of a video display processor's control port. Each 16-bit word written to the port is either a register write completed in one word, or one half of a two-word command. A command loads a 16-bit VRAM address register and a 6-bit access code. A pending flag records that the first half has arrived. The top two address bits of a command persist in a latch, so a later first half reuses them. When the second half sets the DMA request bit of the code and the DMA enable bit in register 1 is set, the block issues a one-cycle DMA start pulse together with the transfer mode taken from register 23.

A control read returns a status word without delay. The read has side effects. It cancels a half-finished command. It clears the sticky sprite flags. It clears the vertical interrupt flag unless vertical blank is in progress. The level status bits are registered copies of inputs from the raster, FIFO and DMA logic. The sticky bits are set by one-cycle event pulses. The address, the code and the whole register file are outputs that feed the data port and DMA engines.

Top module: `vctl_cmd_decoder`

## Requirements
- R1: With no command pending, a written word whose bits [15:14] are 2'b10 is a register write. Bits [12:8] select the register and bits [7:0] become its value on the next clock.
- R2: All 24 registers reset to zero. A register write to index 24 through 31 changes no register.
- R3: A word written with no command pending sets address [13:0] from data [13:0], address [15:14] from the latch, and code [1:0] from data [15:14]. It keeps code [5:2]. It sets the pending flag unless it is a register write. A register write also updates the address and code in this way.
- R4: A word written while pending clears the pending flag. It sets address [15:14] from data [1:0] and code [5:2] from data [7:4], and it copies data [1:0] into the latch. Address [13:0] and code [1:0] are kept.
- R5: `dma_start` is high for exactly the one cycle after a second-half write whose data bit 7 is 1, when register 1 bit 4 was 1 at that write. `dma_mode` then equals register 23 bits [7:6] (00 and 01 mean bus transfer, 10 fill, 11 copy) and holds until the next start.
- R6: The read word is laid out as follows: bit 0 is `pal_mode` (live), 1 DMA busy, 2 hblank, 3 vblank, 4 odd field, 5 sprite collision, 6 sprite overflow, 7 vertical interrupt, 8 FIFO full, 9 FIFO empty, and bits [15:10] are zero. Bits 1–4, 8 and 9 show the matching input from the previous cycle. Bits 5–7 are set by their event pulses and stay set until cleared.
- R7: A read with no write in the same cycle clears the pending flag. Every read clears sprite collision and sprite overflow. A read also clears the vertical interrupt flag when the stored vblank bit is 0.
- R8: While register 1 bit 6 (display enable) is 0, the read word has bit 3 set.
- R9: After reset the address, code, pending flag, latch and DMA outputs are zero. The stored status is 0x0200, so a read straight after reset returns 0x0208.
- R10: An event pulse in the same cycle as a read leaves its flag set. A control write in the same cycle as a read is processed and its effect on the pending flag takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr_en | input | 1 | Control word write strobe |
| ctrl_wr_data | input | 16 | Control word |
| ctrl_rd_en | input | 1 | Control read strobe (applies side effects) |
| ctrl_rd_data | output | 16 | Status word, valid in the read cycle |
| pal_mode | input | 1 | 50 Hz timing indicator |
| dma_busy | input | 1 | DMA engine busy level |
| hblank | input | 1 | Horizontal blank level |
| vblank | input | 1 | Vertical blank level |
| odd_field | input | 1 | Odd interlace field level |
| fifo_full | input | 1 | Write FIFO full level |
| fifo_empty | input | 1 | Write FIFO empty level |
| sprite_coll_evt | input | 1 | Sprite collision event pulse |
| sprite_ovf_evt | input | 1 | Sprite overflow event pulse |
| vint_evt | input | 1 | Vertical interrupt event pulse |
| vram_addr | output | 16 | Address register |
| access_code | output | 6 | Access code register |
| cmd_pending | output | 1 | First command half received |
| dma_start | output | 1 | One-cycle DMA start pulse |
| dma_mode | output | 2 | Mode of the last DMA start |
| regs_flat | output | 192 | Register file, register n at bits [8n+7:8n] |

## Verification
Two kinds of event can land in the same clock. A status read can meet a control write, which collides on the pending flag. A status read can meet a sprite or vertical interrupt event pulse, which collides on a sticky flag. Directed sequences drive both pairs together, with the first half of a command pending and with vblank set and clear. A random phase then drives them often. A cycle-level model in the bench applies the stated precedences and judges every output on every clock.

// File: rtl/vctl_pkg.sv
// Package: shared constants and types for the video control port decoder.
// Assumes 16-bit control words and 8-bit registers.
package vctl_pkg;
    localparam int WORD_W      = 16;
    localparam int ADDR_W      = 16;
    localparam int CODE_W      = 6;
    localparam int NUM_REGS    = 24;
    localparam int REG_W       = 8;
    localparam int IDX_W       = 5;
    localparam int REG_DMA_CFG = 1;   // register holding DMA enable and display enable
    localparam int REG_DMA_SRC = 23;  // register holding the DMA mode field
    localparam int BIT_DMA_EN  = 4;
    localparam int BIT_DISP_EN = 6;

    // status word bit positions
    localparam int ST_PAL   = 0;
    localparam int ST_DMA   = 1;
    localparam int ST_HBL   = 2;
    localparam int ST_VBL   = 3;
    localparam int ST_ODD   = 4;
    localparam int ST_COLL  = 5;
    localparam int ST_OVF   = 6;
    localparam int ST_VINT  = 7;
    localparam int ST_FULL  = 8;
    localparam int ST_EMPTY = 9;
    localparam logic [WORD_W-1:0] STATUS_RESET = 16'h0200;

    typedef enum logic [1:0] {
        DMA_BUS0 = 2'b00,
        DMA_BUS1 = 2'b01,
        DMA_FILL = 2'b10,
        DMA_COPY = 2'b11
    } dma_mode_e;
endpackage

// File: rtl/vctl_regfile.sv
// Module: register file written by single-word register writes.
// Assumes at most one write per cycle; indices at or beyond NUM_REGS are dropped.
module vctl_regfile #(
    parameter int NUM_REGS = 24,
    parameter int REG_W    = 8,
    parameter int IDX_W    = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_stb,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [REG_W-1:0]          wr_val,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);
    localparam int FLAT_W = NUM_REGS * REG_W;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        // one storage register per index, loaded on a matching write
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_flat[g*REG_W +: REG_W] <= '0;
            else if (wr_stb && (wr_idx == IDX_W'(g)))
                regs_flat[g*REG_W +: REG_W] <= wr_val;
        end
    end

    // R2: an out-of-range index leaves every register untouched
    a_r2_high_index_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (int'(wr_idx) >= NUM_REGS)) |=> $stable(regs_flat))
        else $error("R2 violated: register file changed on out-of-range write");

    // R1: an in-range write lands in its register
    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && (int'(wr_idx) < NUM_REGS)) |=>
            (regs_flat[int'($past(wr_idx))*REG_W +: REG_W] == $past(wr_val)))
        else $error("R1 violated: register write not stored");

    logic unused_w;
    assign unused_w = ^FLAT_W;
endmodule

// File: rtl/vctl_cmd_track.sv
// Module: two-word command tracker holding address, code, pending flag and
// the latched upper address bits; raises the DMA start pulse.
// Assumes register values reg_dma_en / reg_mode are the values before this clock.
module vctl_cmd_track
    import vctl_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 16,
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              reg_dma_en,
    input  logic [1:0]        reg_mode,
    output logic              is_reg_write,
    output logic [ADDR_W-1:0] addr_q,
    output logic [CODE_W-1:0] code_q,
    output logic              pending_q,
    output logic              dma_start_q,
    output dma_mode_e         dma_mode_q
);
    localparam int LO_ADDR_W = ADDR_W - 2;
    localparam int HI_CODE_W = CODE_W - 2;

    logic [1:0] hi_latch_q;
    logic       first_half;
    logic       second_half;
    logic       dma_req;

    // classify the incoming word by the pending state
    always_comb begin
        first_half   = wr_en && !pending_q;
        second_half  = wr_en && pending_q;
        is_reg_write = first_half && (wr_data[WORD_W-1 -: 2] == 2'b10);
        dma_req      = second_half && wr_data[7] && reg_dma_en;
    end

    // address, upper-bit latch and code register updates
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            code_q     <= '0;
            hi_latch_q <= '0;
        end else if (first_half) begin
            addr_q <= {hi_latch_q, wr_data[LO_ADDR_W-1:0]};
            code_q <= {code_q[CODE_W-1:2], wr_data[WORD_W-1 -: 2]};
        end else if (second_half) begin
            addr_q     <= {wr_data[1:0], addr_q[LO_ADDR_W-1:0]};
            hi_latch_q <= wr_data[1:0];
            code_q     <= {wr_data[4 +: HI_CODE_W], code_q[1:0]};
        end
    end

    // pending flag: set by a command first half, cleared by second half or read
    always_ff @(posedge clk) begin
        if (!rst_n)
            pending_q <= 1'b0;
        else if (first_half)
            pending_q <= !is_reg_write;
        else if (second_half || rd_en)
            pending_q <= 1'b0;
    end

    // DMA start pulse and captured mode
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_start_q <= 1'b0;
            dma_mode_q  <= DMA_BUS0;
        end else begin
            dma_start_q <= dma_req;
            if (dma_req)
                dma_mode_q <= dma_mode_e'(reg_mode);
        end
    end

    // R3: a non-register first half leaves a command pending
    a_r3_first_half_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !pending_q && (wr_data[WORD_W-1 -: 2] != 2'b10)) |=> pending_q)
        else $error("R3 violated: pending not set");

    // R4: second half closes the command and loads the upper address bits
    a_r4_second_half_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && pending_q) |=> (!pending_q && (addr_q[ADDR_W-1 -: 2] == $past(wr_data[1:0]))))
        else $error("R4 violated: second half handling");

    // R7: a read without a write cancels the pending command
    a_r7_read_cancels: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en) |=> !pending_q)
        else $error("R7 violated: read left command pending");

    // R5: a DMA start only follows a second-half write
    a_r5_dma_after_second: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start_q |-> $past(wr_en && pending_q && wr_data[7]))
        else $error("R5 violated: spurious DMA start");
endmodule

// File: rtl/vctl_status.sv
// Module: status word storage and read side effects.
// Assumes level inputs are sampled each cycle and event inputs are one-cycle pulses.
module vctl_status
    import vctl_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              display_en,
    input  logic              pal_mode,
    input  logic              dma_busy,
    input  logic              hblank,
    input  logic              vblank,
    input  logic              odd_field,
    input  logic              fifo_full,
    input  logic              fifo_empty,
    input  logic              coll_evt,
    input  logic              ovf_evt,
    input  logic              vint_evt,
    output logic [WORD_W-1:0] rd_word
);
    logic [WORD_W-1:0] stat_q;
    logic [WORD_W-1:0] stat_d;

    // next status: refresh levels, apply read clears, then let events win
    always_comb begin
        stat_d           = '0;
        stat_d[ST_DMA]   = dma_busy;
        stat_d[ST_HBL]   = hblank;
        stat_d[ST_VBL]   = vblank;
        stat_d[ST_ODD]   = odd_field;
        stat_d[ST_FULL]  = fifo_full;
        stat_d[ST_EMPTY] = fifo_empty;
        stat_d[ST_COLL]  = (stat_q[ST_COLL] && !rd_en) || coll_evt;
        stat_d[ST_OVF]   = (stat_q[ST_OVF]  && !rd_en) || ovf_evt;
        stat_d[ST_VINT]  = (stat_q[ST_VINT] && !(rd_en && !stat_q[ST_VBL])) || vint_evt;
    end

    // status register
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat_q <= STATUS_RESET;
        else
            stat_q <= stat_d;
    end

    // returned word: live PAL bit and forced vblank while the display is off
    always_comb begin
        rd_word         = stat_q;
        rd_word[ST_PAL] = pal_mode;
        if (!display_en)
            rd_word[ST_VBL] = 1'b1;
    end

    // R7: a read with no new collision clears the collision flag
    a_r7_coll_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !coll_evt) |=> !stat_q[ST_COLL])
        else $error("R7 violated: collision flag survived read");

    // R7: inside vblank a read keeps the vertical interrupt flag
    a_r7_vint_kept_in_vblank: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && stat_q[ST_VBL] && stat_q[ST_VINT]) |=> stat_q[ST_VINT])
        else $error("R7 violated: vint flag cleared during vblank");

    // R10: an event pulse always leaves its flag set
    a_r10_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (vint_evt && ovf_evt) |=> (stat_q[ST_VINT] && stat_q[ST_OVF]))
        else $error("R10 violated: event lost to read clear");
endmodule

// File: rtl/vctl_cmd_decoder.sv
// Module: top of the video control port decoder. Splits register writes from
// command words, holds the register file, and serves status reads.
// Assumes one control access of each kind per cycle at most.
module vctl_cmd_decoder
    import vctl_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ctrl_wr_en,
    input  logic [WORD_W-1:0]         ctrl_wr_data,
    input  logic                      ctrl_rd_en,
    output logic [WORD_W-1:0]         ctrl_rd_data,
    input  logic                      pal_mode,
    input  logic                      dma_busy,
    input  logic                      hblank,
    input  logic                      vblank,
    input  logic                      odd_field,
    input  logic                      fifo_full,
    input  logic                      fifo_empty,
    input  logic                      sprite_coll_evt,
    input  logic                      sprite_ovf_evt,
    input  logic                      vint_evt,
    output logic [ADDR_W-1:0]         vram_addr,
    output logic [CODE_W-1:0]         access_code,
    output logic                      cmd_pending,
    output logic                      dma_start,
    output logic [1:0]                dma_mode,
    output logic [NUM_REGS*REG_W-1:0] regs_flat
);
    logic            reg_wr;
    logic [REG_W-1:0] cfg_reg;
    logic [REG_W-1:0] src_reg;
    dma_mode_e       mode_q;

    // pick the configuration registers out of the flat bus
    always_comb begin
        cfg_reg  = regs_flat[REG_DMA_CFG*REG_W +: REG_W];
        src_reg  = regs_flat[REG_DMA_SRC*REG_W +: REG_W];
        dma_mode = mode_q;
    end

    vctl_cmd_track #(
        .WORD_W (WORD_W),
        .ADDR_W (ADDR_W),
        .CODE_W (CODE_W)
    ) i_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (ctrl_wr_en),
        .wr_data      (ctrl_wr_data),
        .rd_en        (ctrl_rd_en),
        .reg_dma_en   (cfg_reg[BIT_DMA_EN]),
        .reg_mode     (src_reg[REG_W-1 -: 2]),
        .is_reg_write (reg_wr),
        .addr_q       (vram_addr),
        .code_q       (access_code),
        .pending_q    (cmd_pending),
        .dma_start_q  (dma_start),
        .dma_mode_q   (mode_q)
    );

    vctl_regfile #(
        .NUM_REGS (NUM_REGS),
        .REG_W    (REG_W),
        .IDX_W    (IDX_W)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (reg_wr),
        .wr_idx    (ctrl_wr_data[8 +: IDX_W]),
        .wr_val    (ctrl_wr_data[REG_W-1:0]),
        .regs_flat (regs_flat)
    );

    vctl_status #(
        .WORD_W (WORD_W)
    ) i_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_en      (ctrl_rd_en),
        .display_en (cfg_reg[BIT_DISP_EN]),
        .pal_mode   (pal_mode),
        .dma_busy   (dma_busy),
        .hblank     (hblank),
        .vblank     (vblank),
        .odd_field  (odd_field),
        .fifo_full  (fifo_full),
        .fifo_empty (fifo_empty),
        .coll_evt   (sprite_coll_evt),
        .ovf_evt    (sprite_ovf_evt),
        .vint_evt   (vint_evt),
        .rd_word    (ctrl_rd_data)
    );

    // R10: a write in the read cycle decides the pending flag
    a_r10_write_beats_read: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd_en && ctrl_wr_en && !cmd_pending && (ctrl_wr_data[15:14] != 2'b10)) |=> cmd_pending)
        else $error("R10 violated: read overrode a first-half write");

    // R6: the upper six bits of the read word are always zero
    a_r6_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rd_data[15:10] == 6'd0)
        else $error("R6 violated: upper status bits nonzero");
endmodule

// File: tb/test_vctl_cmd_decoder.sv
module test_vctl_cmd_decoder;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en, rd_en;
    logic [15:0]  wr_data;
    logic         pal, dbusy, hbl, vbl, odd, ffull, fempty, coll, ovf, vint;
    logic [15:0]  rd_data, vram_addr;
    logic [5:0]   acode;
    logic         pend, dstart;
    logic [1:0]   dmode;
    logic [191:0] regs;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    int m_regs[24];
    int m_addr, m_code, m_pend, m_latch, m_dstart, m_dmode, m_stat;

    always #5 clk = ~clk;

    vctl_cmd_decoder i_vctl_cmd_decoder (
        .clk(clk), .rst_n(rst_n), .ctrl_wr_en(wr_en), .ctrl_wr_data(wr_data),
        .ctrl_rd_en(rd_en), .ctrl_rd_data(rd_data), .pal_mode(pal),
        .dma_busy(dbusy), .hblank(hbl), .vblank(vbl), .odd_field(odd),
        .fifo_full(ffull), .fifo_empty(fempty), .sprite_coll_evt(coll),
        .sprite_ovf_evt(ovf), .vint_evt(vint), .vram_addr(vram_addr),
        .access_code(acode), .cmd_pending(pend), .dma_start(dstart),
        .dma_mode(dmode), .regs_flat(regs)
    );

    task automatic check(input string tag, input logic [191:0] act, input logic [191:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_rd();
        logic [15:0] w;
        w = 16'(m_stat);
        w[0] = pal;
        if (((m_regs[1] >> 6) & 1) == 0) w[3] = 1'b1;
        return w;
    endfunction

    task automatic model_edge();
        int ns;
        int d;
        d = int'(wr_data);
        if (!rst_n) begin
            foreach (m_regs[i]) m_regs[i] = 0;
            m_addr = 0; m_code = 0; m_pend = 0; m_latch = 0;
            m_dstart = 0; m_dmode = 0; m_stat = 'h200;
            return;
        end
        // status
        ns = 0;
        if (dbusy)  ns |= 1 << 1;
        if (hbl)    ns |= 1 << 2;
        if (vbl)    ns |= 1 << 3;
        if (odd)    ns |= 1 << 4;
        if (ffull)  ns |= 1 << 8;
        if (fempty) ns |= 1 << 9;
        if ((m_stat & 'h20) && !rd_en) ns |= 'h20;
        if ((m_stat & 'h40) && !rd_en) ns |= 'h40;
        if ((m_stat & 'h80) && !(rd_en && !(m_stat & 'h8))) ns |= 'h80;
        if (coll) ns |= 'h20;
        if (ovf)  ns |= 'h40;
        if (vint) ns |= 'h80;
        m_stat = ns;
        // command path
        m_dstart = 0;
        if (wr_en) begin
            if (m_pend == 0) begin
                if (((d >> 14) & 3) == 2) begin
                    if (((d >> 8) & 31) < 24) m_regs[(d >> 8) & 31] = d & 255;
                end else m_pend = 1;
                m_addr = (m_latch << 14) | (d & 'h3FFF);
                m_code = (m_code & 'h3C) | ((d >> 14) & 3);
            end else begin
                m_pend  = 0;
                m_addr  = (m_addr & 'h3FFF) | ((d & 3) << 14);
                m_latch = d & 3;
                m_code  = (m_code & 3) | ((d >> 2) & 'h3C);
                if (((m_code >> 5) & 1) && ((m_regs[1] >> 4) & 1)) begin
                    m_dstart = 1;
                    m_dmode  = (m_regs[23] >> 6) & 3;
                end
            end
        end else if (rd_en) m_pend = 0;
    endtask

    task automatic compare_all();
        logic [191:0] er;
        er = '0;
        for (int i = 0; i < 24; i++) er[i*8 +: 8] = 8'(m_regs[i]);
        check("R1 register file", regs, er);
        check("R3 address", 192'(vram_addr), 192'(m_addr));
        check("R4 access code", 192'(acode), 192'(m_code));
        check("R10 pending flag", 192'(pend), 192'(m_pend));
        check("R5 dma start", 192'(dstart), 192'(m_dstart));
        check("R5 dma mode", 192'(dmode), 192'(m_dmode));
    endtask

    // one clock: drive, check combinational read word, clock model, compare
    task automatic step(input logic w, input logic [15:0] wd, input logic r,
                        input logic c = 0, input logic o = 0, input logic v = 0);
        wr_en = w; wr_data = wd; rd_en = r; coll = c; ovf = o; vint = v;
        #1;
        if (rst_n) check("R6 status word", 192'(rd_data), 192'(exp_rd()));
        @(posedge clk);
        #1;
        model_edge();
        @(negedge clk);
        if (rst_n) compare_all();
        wr_en = 0; rd_en = 0; coll = 0; ovf = 0; vint = 0;
    endtask

    task automatic idle(); step(0, 16'h0, 0); endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 0; wr_en = 0; rd_en = 0; wr_data = 0;
        pal = 0; dbusy = 0; hbl = 0; vbl = 0; odd = 0; ffull = 0; fempty = 0;
        coll = 0; ovf = 0; vint = 0;
        @(negedge clk);
        step(0, 0, 0); step(0, 0, 0);
        rst_n = 1;
        // R9: reset state seen at the ports
        #1;
        check("R9 reset read word", 192'(rd_data), 192'(16'h0208));
        check("R9 reset address", 192'(vram_addr), 192'(0));
        check("R9 reset pending", 192'(pend), 192'(0));
        check("R2 reset registers", regs, 192'(0));
        idle();

        // R1: register writes, including last index
        step(1, 16'h8150, 0);   // reg1 = 0x50 : display on, DMA enable
        step(1, 16'h97C0, 0);   // reg23 = 0xC0 : copy mode
        step(1, 16'h8A5A, 0);
        // R2: indices 24 and 31 ignored
        step(1, 16'h98FF, 0);
        step(1, 16'h9FAA, 0);
        // R3/R4: command pair with upper bits and latch reuse
        step(1, 16'h5234, 0);
        step(1, 16'h0012, 0);
        step(1, 16'h4001, 0);   // first half reuses latched upper bits
        step(0, 0, 1);          // R7: read cancels pending
        // R5: DMA start, copy mode
        step(1, 16'h4100, 0);
        step(1, 16'h0080, 0);
        idle();
        // R5: DMA bit set but enable off
        step(1, 16'h8140, 0);
        step(1, 16'h4100, 0);
        step(1, 16'h00F0, 0);
        // R5: fill mode after enable
        step(1, 16'h8154, 0);
        step(1, 16'h9780, 0);
        step(1, 16'h0000, 0);
        step(1, 16'h00A3, 0);
        idle();
        // R8: display off forces vblank bit
        step(1, 16'h8110, 0);
        step(0, 0, 1);
        step(1, 16'h8150, 0);
        // R7: events then reads inside and outside vblank
        step(0, 0, 0, 1, 1, 1);
        vbl = 1; idle();
        step(0, 0, 1);          // vint kept in vblank
        vbl = 0; idle();
        step(0, 0, 1);          // vint cleared outside vblank
        // R10: events coincide with a read
        step(0, 0, 1, 1, 1, 1);
        step(0, 0, 1);
        // R10: write in the same cycle as a read
        step(1, 16'h1234, 1);
        step(1, 16'h0003, 1);
        // R6: level bits
        pal = 1; dbusy = 1; hbl = 1; odd = 1; ffull = 1; fempty = 1; idle(); idle();
        pal = 0; dbusy = 0; hbl = 0; odd = 0; ffull = 0; fempty = 0; idle(); idle();

        // random phase
        for (int k = 0; k < 3000; k++) begin
            logic [15:0] wd;
            wd = 16'($urandom);
            if ($urandom_range(0, 3) == 0) wd[15:14] = 2'b10;
            if ($urandom_range(0, 2) == 0) wd[12:8] = 5'($urandom_range(0, 1) ? 1 : 23);
            pal = 1'($urandom); dbusy = 1'($urandom); hbl = 1'($urandom);
            vbl = 1'($urandom); odd = 1'($urandom); ffull = 1'($urandom);
            fempty = 1'($urandom);
            step(1'($urandom), wd, 1'($urandom_range(0, 2) == 0),
                 1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 3) == 0),
                 1'($urandom_range(0, 3) == 0));
        end
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule